// File: doc/BRIEF.md
# CAN Controller Sleep Sequencer

This block puts a CAN controller into a low-power sleep state and brings it back out. Software asks for sleep by setting a request bit in the control register. If a frame is being sent at that moment, the sequencer waits until the frame ends. The frame can end by success, by losing arbitration or by a bus error. Only then does the sequencer drop the clock enable of the gated protocol domain and report the acknowledge state.

The sequencer runs on the always-on clock. It holds the request bit and the wake-enable bit itself, and it answers register reads while the gated domain is stopped. In sleep, the status address reads as a single acknowledge bit and every other address reads as zero.

There are two ways to wake. Software can clear the request bit. Or, when wake-enable is set, a dominant edge on the synchronized RX line starts a power-up sequence. In that sequence the gated clock runs again, but the controller stays off the bus until eleven recessive bits in a row have been sampled. As a result, the frame that caused the wake is not received. When the power-up sequence completes, the request bit and the acknowledge state are cleared. Error counters live in the gated domain, and nothing here touches them.

Top module: `can_sleep_seq`

## Requirements
- R1: After reset, clk_en and bus_active are 1, and the request bit (bit 11) and wake-enable bit (bit 10) of the control register read as 0.
- R2: Writing 1 to control bit 11 while tx_busy is 0 makes clk_en and bus_active 0 within two clock cycles of the write.
- R3: If tx_busy is 1 when sleep is requested, clk_en stays 1 until one of tx_ok, tx_lost or tx_err pulses, and clk_en drops on that pulse.
- R4: While the block is not bus-active, a read returns 0x0008 (acknowledge, bit 3) at the status address and 0x0000 at every other address, including the control address.
- R5: While bus-active, a read returns core_rdata, with two exceptions. At the control address, bits 11 and 10 are replaced by the stored request and wake-enable bits. At the status address, bit 3 reads 0.
- R6: Clearing control bit 11 during sleep or power-up returns the block to the awake state (clk_en 1, bus_active 1) on the next cycle.
- R7: When wake-enable is 0, RX activity during sleep has no effect. clk_en stays 0 and the status read stays 0x0008.
- R8: When wake-enable is 1, a falling edge on the synchronized RX line during sleep sets clk_en to 1 while bus_active stays 0, and reads stay masked.
- R9: During power-up, bus_active rises on the bit_tick that samples the eleventh consecutive recessive (1) RX bit. A tick that samples a dominant (0) bit restarts the count from zero.
- R10: When power-up completes through bus activity, the request bit reads 0, the acknowledge bit reads 0 and wake-enable keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; data appears one cycle later |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| core_rdata | input | 16 | Read data from the gated register file for bus_addr |
| tx_busy | input | 1 | A frame is being transmitted |
| tx_ok | input | 1 | Pulse: frame sent successfully |
| tx_lost | input | 1 | Pulse: arbitration lost |
| tx_err | input | 1 | Pulse: frame aborted by a bus error |
| rx_in | input | 1 | Asynchronous CAN RX line |
| bit_tick | input | 1 | One pulse per nominal bit time |
| clk_en | output | 1 | Clock enable for the gated domain |
| bus_active | output | 1 | Controller may take part in bus traffic |

## Verification
The bench uses the default parameters: 16-bit data, 4-bit address, an 11-bit recessive window and a two-stage RX synchronizer. With a 4-bit address, every register address is read in both the awake and the sleep state, so the read mask is covered completely. With an 11-bit window, the position of a dominant interruption can be swept over every count from 0 to 10. Each of the three ways a frame can end is tried against a deferred sleep request.

// File: rtl/can_pd_pkg.sv
// Shared types for the CAN sleep sequencer.
// Assumes: a single always-on clock domain drives all users of these types.
package can_pd_pkg;
    typedef enum logic [1:0] {
        PD_AWAKE  = 2'd0,
        PD_DRAIN  = 2'd1,
        PD_SLEEP  = 2'd2,
        PD_WAKEUP = 2'd3
    } pd_state_t;
endpackage

// File: rtl/can_pd_rxsync.sv
// Synchronizes the asynchronous RX line and flags dominant (falling) edges.
// Assumes: recessive level is 1; the chain resets to recessive so that reset
// release never looks like bus activity.
module can_pd_rxsync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_async,
    output logic rx_level,
    output logic rx_fall
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_one
            // Single-stage capture of the RX line.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= rx_async;
            end
        end else begin : g_chain
            // Shift the RX line through the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= {sync_q[STAGES-2:0], rx_async};
            end
        end
    endgenerate

    // Remember the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= sync_q[STAGES-1];
    end

    assign rx_level = sync_q[STAGES-1];
    assign rx_fall  = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/can_pd_wakecnt.sv
// Counts consecutive recessive bits during power-up and reports when the
// required run length is reached.
// Assumes: tick is a one-cycle pulse per bit time; run is low outside power-up.
module can_pd_wakecnt #(
    parameter int BITS = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    input  logic rx_level,
    output logic done
);
    localparam int CW = $clog2(BITS + 1);
    localparam logic [CW-1:0] LAST = CW'(BITS - 1);

    logic [CW-1:0] cnt_q;

    // Count recessive ticks; a dominant tick or leaving power-up clears it.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt_q <= '0;
        else if (tick)      cnt_q <= rx_level ? cnt_q + 1'b1 : '0;
    end

    assign done = run & tick & rx_level & (cnt_q == LAST);
endmodule

// File: rtl/can_pd_fsm.sv
// Sleep state machine: awake, draining a frame, asleep, powering up.
// Assumes: tx end pulses last one cycle; req and wake_en come from the
// always-on control register.
module can_pd_fsm
    import can_pd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req,
    input  logic      wake_en,
    input  logic      tx_busy,
    input  logic      tx_end,
    input  logic      rx_fall,
    input  logic      wake_done,
    output pd_state_t state,
    output logic      clk_en,
    output logic      bus_active,
    output logic      wake_clr
);
    pd_state_t state_d;

    // Next-state selection.
    always_comb begin
        state_d = state;
        unique case (state)
            PD_AWAKE:  if (req) state_d = (tx_busy && !tx_end) ? PD_DRAIN : PD_SLEEP;
            PD_DRAIN:  if (!req) state_d = PD_AWAKE;
                       else if (tx_end) state_d = PD_SLEEP;
            PD_SLEEP:  if (!req) state_d = PD_AWAKE;
                       else if (wake_en && rx_fall) state_d = PD_WAKEUP;
            PD_WAKEUP: if (!req || wake_done) state_d = PD_AWAKE;
            default:   state_d = PD_AWAKE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= PD_AWAKE;
        else        state <= state_d;
    end

    assign clk_en     = (state != PD_SLEEP);
    assign bus_active = (state == PD_AWAKE) || (state == PD_DRAIN);
    assign wake_clr   = (state == PD_WAKEUP) && req && wake_done;
endmodule

// File: rtl/can_sleep_seq.sv
// Top of the CAN sleep sequencer: always-on control bits, read masking,
// RX wake detection and the gated-domain clock enable.
// Assumes: core_rdata is combinational for bus_addr; reads are registered.
module can_sleep_seq
    import can_pd_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int ADDR_W      = 4,
    parameter int CTRL_ADDR   = 0,
    parameter int STAT_ADDR   = 1,
    parameter int REQ_BIT     = 11,
    parameter int WEN_BIT     = 10,
    parameter int ACK_BIT     = 3,
    parameter int WAKE_BITS   = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] core_rdata,
    input  logic              tx_busy,
    input  logic              tx_ok,
    input  logic              tx_lost,
    input  logic              tx_err,
    input  logic              rx_in,
    input  logic              bit_tick,
    output logic              clk_en,
    output logic              bus_active
);
    localparam logic [ADDR_W-1:0] CTRL_A  = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] STAT_A  = ADDR_W'(STAT_ADDR);
    localparam logic [DATA_W-1:0] ACK_VAL = DATA_W'(1) << ACK_BIT;

    logic              req_q, wake_en_q;
    logic              rx_level, rx_fall, wake_done, wake_clr;
    logic [DATA_W-1:0] rd_mux;
    pd_state_t         state;
    logic              unused_wdata_bits;

    assign unused_wdata_bits = ^bus_wdata;

    can_pd_rxsync #(.STAGES(SYNC_STAGES)) i_rxsync (
        .clk(clk), .rst_n(rst_n), .rx_async(rx_in),
        .rx_level(rx_level), .rx_fall(rx_fall)
    );

    can_pd_wakecnt #(.BITS(WAKE_BITS)) i_wakecnt (
        .clk(clk), .rst_n(rst_n), .run(state == PD_WAKEUP),
        .tick(bit_tick), .rx_level(rx_level), .done(wake_done)
    );

    can_pd_fsm i_fsm (
        .clk(clk), .rst_n(rst_n), .req(req_q), .wake_en(wake_en_q),
        .tx_busy(tx_busy), .tx_end(tx_ok | tx_lost | tx_err),
        .rx_fall(rx_fall), .wake_done(wake_done), .state(state),
        .clk_en(clk_en), .bus_active(bus_active), .wake_clr(wake_clr)
    );

    // Always-on control bits: software writes win over the wake-up clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q     <= 1'b0;
            wake_en_q <= 1'b0;
        end else if (bus_wr && bus_addr == CTRL_A) begin
            req_q     <= bus_wdata[REQ_BIT];
            wake_en_q <= bus_wdata[WEN_BIT];
        end else if (wake_clr) begin
            req_q     <= 1'b0;
        end
    end

    // Read mux: masked while off the bus, patched with local bits otherwise.
    always_comb begin
        if (!bus_active) begin
            rd_mux = (bus_addr == STAT_A) ? ACK_VAL : '0;
        end else begin
            rd_mux = core_rdata;
            if (bus_addr == CTRL_A) begin
                rd_mux[REQ_BIT] = req_q;
                rd_mux[WEN_BIT] = wake_en_q;
            end
            if (bus_addr == STAT_A) rd_mux[ACK_BIT] = 1'b0;
        end
    end

    // Registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end
endmodule

// File: rtl/can_sleep_seq_chk.sv
// Property checker for the CAN sleep sequencer, bound into the top module.
// Assumes: parameters match those of the bound instance.
module can_sleep_seq_chk
    import can_pd_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = 4,
    parameter int STAT_ADDR = 1,
    parameter int ACK_BIT   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              tx_busy,
    input logic              tx_ok,
    input logic              tx_lost,
    input logic              tx_err,
    input logic              bit_tick,
    input logic              clk_en,
    input logic              bus_active,
    input pd_state_t         state,
    input logic              req_q,
    input logic              wake_en_q,
    input logic              wake_done
);
    localparam logic [ADDR_W-1:0] STAT_A  = ADDR_W'(STAT_ADDR);
    localparam logic [DATA_W-1:0] ACK_VAL = DATA_W'(1) << ACK_BIT;

    // R3
    drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_active && tx_busy && !(tx_ok || tx_lost || tx_err)) |=> clk_en);

    // R4
    sleep_read_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_active) |=>
        (bus_rdata == (($past(bus_addr) == STAT_A) ? ACK_VAL : '0)));

    // R6
    sw_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_q && (state == PD_SLEEP || state == PD_WAKEUP)) |=> (state == PD_AWAKE));

    // R7
    no_bus_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PD_SLEEP && req_q && !wake_en_q && !bus_wr) |=> (state == PD_SLEEP));

    // R9
    wake_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PD_WAKEUP && req_q && !bit_tick) |=> !bus_active);

    // R10
    wake_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PD_WAKEUP && req_q && wake_done && !bus_wr) |=>
        (!req_q && wake_en_q == $past(wake_en_q) && bus_active));
endmodule

bind can_sleep_seq can_sleep_seq_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .ACK_BIT(ACK_BIT)
) i_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .tx_busy(tx_busy), .tx_ok(tx_ok),
    .tx_lost(tx_lost), .tx_err(tx_err), .bit_tick(bit_tick), .clk_en(clk_en),
    .bus_active(bus_active), .state(state), .req_q(req_q),
    .wake_en_q(wake_en_q), .wake_done(wake_done)
);

// File: tb/test_can_sleep_seq.sv
`timescale 1ns/1ps
module test_can_sleep_seq;
    localparam int DW = 16;
    localparam int AW = 4;
    localparam logic [AW-1:0] CTRL = 4'd0;
    localparam logic [AW-1:0] STAT = 4'd1;
    localparam logic [DW-1:0] REQ = 16'h0800;
    localparam logic [DW-1:0] WEN = 16'h0400;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [DW-1:0] bus_wdata = '0, bus_rdata, core_rdata;
    logic tx_busy = 1'b0, tx_ok = 1'b0, tx_lost = 1'b0, tx_err = 1'b0;
    logic rx_in = 1'b1, bit_tick = 1'b0;
    logic clk_en, bus_active;
    int checks = 0, failures = 0;
    bit done_flag = 1'b0;

    always #2.5 clk = ~clk;

    assign core_rdata = {bus_addr, ~bus_addr, bus_addr, ~bus_addr};

    can_sleep_seq i_can_sleep_seq (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .core_rdata(core_rdata), .tx_busy(tx_busy), .tx_ok(tx_ok),
        .tx_lost(tx_lost), .tx_err(tx_err), .rx_in(rx_in),
        .bit_tick(bit_tick), .clk_en(clk_en), .bus_active(bus_active)
    );

    function automatic logic [DW-1:0] awake_val(input logic [AW-1:0] a,
                                                input logic rq, input logic we);
        logic [DW-1:0] v;
        v = {a, ~a, a, ~a};
        if (a == CTRL) begin v[11] = rq; v[10] = we; end
        if (a == STAT) v[3] = 1'b0;
        return v;
    endfunction

    task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
    endtask

    task automatic tick();
        @(negedge clk); bit_tick = 1'b1;
        @(negedge clk); bit_tick = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Enter sleep with wake-enable and trigger a bus wake.
    task automatic sleep_and_bus_wake();
        wr(CTRL, REQ | WEN); idle(1);
        rx_in = 1'b0; idle(5);
        rx_in = 1'b1; idle(4);
    endtask

    initial begin
        #(200000 * 5);
        if (!done_flag) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] d;
        idle(4); rst_n = 1'b1; idle(1);

        // R1: reset state
        check("R1 clk_en", {15'd0, clk_en}, 16'd1);
        check("R1 bus_active", {15'd0, bus_active}, 16'd1);
        rd(CTRL, d); check("R1 ctrl", d, awake_val(CTRL, 0, 0));

        // R5: awake reads at every address
        for (int a = 0; a < 16; a++) begin
            rd(AW'(a), d); check("R5 awake read", d, awake_val(AW'(a), 0, 0));
        end

        // R2: immediate sleep without a frame in flight
        wr(CTRL, REQ); idle(1);
        check("R2 clk_en", {15'd0, clk_en}, 16'd0);
        check("R2 bus_active", {15'd0, bus_active}, 16'd0);

        // R4: every address masked in sleep
        for (int a = 0; a < 16; a++) begin
            rd(AW'(a), d); check("R4 sleep read", d, (AW'(a) == STAT) ? 16'h0008 : 16'h0000);
        end

        // R6: software clear wakes from sleep
        wr(CTRL, 16'h0000); idle(1);
        check("R6 clk_en", {15'd0, clk_en}, 16'd1);
        check("R6 bus_active", {15'd0, bus_active}, 16'd1);
        rd(STAT, d); check("R6 status", d, awake_val(STAT, 0, 0));

        // R3: deferral for each kind of frame end
        for (int k = 0; k < 3; k++) begin
            tx_busy = 1'b1;
            wr(CTRL, REQ); idle(8);
            check("R3 held awake", {15'd0, clk_en}, 16'd1);
            @(negedge clk);
            tx_busy = 1'b0;
            tx_ok = (k == 0); tx_lost = (k == 1); tx_err = (k == 2);
            @(negedge clk);
            tx_ok = 1'b0; tx_lost = 1'b0; tx_err = 1'b0;
            check("R3 slept on end", {15'd0, clk_en}, 16'd0);
            wr(CTRL, 16'h0000); idle(1);
        end

        // R7: RX activity ignored with wake-enable clear
        wr(CTRL, REQ); idle(1);
        for (int i = 0; i < 3; i++) begin
            rx_in = 1'b0; idle(6); rx_in = 1'b1; idle(6);
        end
        check("R7 clk_en", {15'd0, clk_en}, 16'd0);
        rd(STAT, d); check("R7 status", d, 16'h0008);

        // R8: bus wake starts power-up, bus stays off and reads stay masked
        wr(CTRL, REQ | WEN); idle(1);
        rx_in = 1'b0; idle(5); rx_in = 1'b1; idle(4);
        check("R8 clk_en", {15'd0, clk_en}, 16'd1);
        check("R8 bus_active", {15'd0, bus_active}, 16'd0);
        rd(CTRL, d); check("R8 ctrl masked", d, 16'h0000);
        rd(STAT, d); check("R8 status", d, 16'h0008);

        // R6: software clear during power-up
        wr(CTRL, WEN); idle(1);
        check("R6 clear in power-up", {15'd0, bus_active}, 16'd1);

        // R9/R10: dominant interruption at every count position
        for (int k = 0; k <= 10; k++) begin
            sleep_and_bus_wake();
            for (int t = 0; t < k; t++) tick();
            rx_in = 1'b0; idle(4); tick(); rx_in = 1'b1; idle(4);
            for (int t = 0; t < 10; t++) tick();
            check("R9 before eleventh", {15'd0, bus_active}, 16'd0);
            tick();
            check("R9 after eleventh", {15'd0, bus_active}, 16'd1);
            rd(CTRL, d); check("R10 ctrl", d, awake_val(CTRL, 0, 1));
            rd(STAT, d); check("R10 status", d, awake_val(STAT, 0, 1));
        end

        done_flag = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule